// File: doc/BRIEF.md
# Flash Program/Erase Status Word Generator

This block builds the word that a flash read returns while an internal program or erase job is running, suspended or finished. A command decoder elsewhere tells it when a job starts (on the last cycle of the command sequence), what kind of job it is, which address it targets and, for a program, the word being written. The block times the job itself and pulses `done_o` when the job ends.

Each read strobe is answered one cycle later on `rd_data_o`. The answer is either the array word passed in on `array_data_i`, or that word with bits 7, 6 and 2 replaced by status. The status bits let software poll for completion. Bit 7 gives the inverted-data or zero poll. Bit 6 is a toggle bit for any busy job. Bit 2 is a second toggle that tells an erasing or erase-suspended region apart from a program.

Sector and block erases can be paused. The pause takes a fixed number of cycles to take effect, and this number is bounded. While the erase is paused, one program job outside the paused region may run, and reads outside that region see the array. The asynchronous reset models the hardware reset pin. It abandons any job and returns reads to array data.

Top module: `flash_status_gen`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `busy_o`, `suspended_o` and `done_o` are 0 and `rd_data_o` is 0. A job in flight, suspended or not, is abandoned, and the next read returns array data.
- R2: With no job outstanding, a read sampled on a clock edge returns `array_data_i` unchanged on `rd_data_o` after that edge. `rd_data_o` holds its value when `rd_i` is low.
- R3: While a program runs (op code 2'b00), bit 7 of a read is the inverse of bit 7 of the word being programmed. All bits other than 7, 6 and 2 come from `array_data_i`.
- R4: During a program or erase, bit 6 reads 0 on the first read after the job starts and then alternates on each later read. Both toggle states clear to 0 whenever a job is accepted.
- R5: Bit 2 does not toggle during a program and reads 0 there. During an erase it alternates on each read, starting from 0.
- R6: While an erase runs (op 2'b01 sector, 2'b10 block, 2'b11 whole array), bit 7 reads 0.
- R7: An accepted job keeps `busy_o` high for exactly PROG_CYCLES cycles (program), ERASE_CYCLES cycles (sector or block erase) or CHIP_CYCLES cycles (whole array). `done_o` is then high for exactly one cycle, and later reads return array data.
- R8: While a program or erase is active, `start_i` is ignored. `suspend_i` is ignored during a program and during a whole-array erase.
- R9: When `suspend_i` is accepted during a sector or block erase, the erase status continues for exactly SUSP_LAT cycles, and then `suspended_o` rises. SUSP_LAT never exceeds the SUSP_MAX bound.
- R10: While suspended, a read whose address lies in the paused region returns bit 7 = 1, bit 6 = 1 and a toggling bit 2. A read elsewhere returns array data. The region is defined as follows. For a sector erase, it is the addresses that share bits [ADDR_W-1:SECTOR_BITS] with the erase address. For a block erase, it is the addresses that share bits [ADDR_W-1:BLOCK_BITS].
- R11: While suspended, a program start outside the paused region is accepted. It reports program status as in R3 and R4, and it pulses `done_o` after PROG_CYCLES cycles while `suspended_o` stays high. A program start inside the region is ignored.
- R12: `resume_i` while suspended restarts the erase where it stopped. The cycles during which `busy_o` is high and `suspended_o` is low add up to exactly the erase duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, also the hardware abort |
| start_i | input | 1 | Job start from the command decoder (last command cycle) |
| op_i | input | 2 | Job kind: 00 program, 01 sector erase, 10 block erase, 11 whole-array erase |
| start_addr_i | input | ADDR_W | Target address of the job |
| prog_data_i | input | DATA_W | Word being programmed |
| suspend_i | input | 1 | Pause request for an erase |
| resume_i | input | 1 | Resume request for a paused erase |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | DATA_W | Array word at the read address |
| rd_data_o | output | DATA_W | Read result, valid the cycle after the strobe |
| busy_o | output | 1 | A job is outstanding (running or paused) |
| suspended_o | output | 1 | The erase is paused |
| done_o | output | 1 | One-cycle pulse when a job completes |

## Verification
The assertions check the following on every cycle:
- the single-cycle `done_o` pulse;
- idle pass-through reads;
- the inverted bit 7 during a program;
- the all-ones status pair inside a paused region;
- that a rejected start leaves the latched program word alone;
- that erase progress is frozen while paused;
- that the pause entry never outlasts its bound.

Only the bench scenarios can show the sequence-level behaviour:
- the exact job durations, including an erase split by a pause and a nested program;
- the alternation order of bits 6 and 2 across consecutive reads;
- the clearing of the toggles when a new job is accepted;
- region granularity for sector versus block erase;
- recovery to array reads after a mid-job reset.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_BLK  = 2'b10,
    OP_CHIP = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_SUSPENDING,
    ST_SUSPENDED,
    ST_SUSP_PROG
  } st_e;

  typedef enum logic [1:0] {
    RM_ARRAY,
    RM_PROG,
    RM_ERASE,
    RM_HIT
  } rmode_e;
endpackage

// File: rtl/sg_cycle_timer.sv
module sg_cycle_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          run_i,
  output logic          expire_o,
  output logic [CW-1:0] remain_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && !load_i && (cnt_q == '0);
  assign remain_o = cnt_q;
endmodule

// File: rtl/sg_toggle_bank.sv
module sg_toggle_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic [N-1:0] flip_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_tog
    logic t_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        t_q <= 1'b0;
      else if (clear_i)   t_q <= 1'b0;
      else if (flip_i[g]) t_q <= ~t_q;
    end
    assign q_o[g] = t_q;
  end
endmodule

// File: rtl/sg_status_word.sv
module sg_status_word
  import sg_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  rmode_e            mode_i,
  input  logic [DATA_W-1:0] array_i,
  input  logic              pbit7_i,
  input  logic              tog6_i,
  input  logic              tog2_i,
  output logic [DATA_W-1:0] word_o,
  output logic              flip6_o,
  output logic              flip2_o
);
  always_comb begin
    word_o  = array_i;
    flip6_o = 1'b0;
    flip2_o = 1'b0;
    unique case (mode_i)
      RM_PROG: begin
        word_o[7] = ~pbit7_i;
        word_o[6] = tog6_i;
        word_o[2] = tog2_i;
        flip6_o   = 1'b1;
      end
      RM_ERASE: begin
        word_o[7] = 1'b0;
        word_o[6] = tog6_i;
        word_o[2] = tog2_i;
        flip6_o   = 1'b1;
        flip2_o   = 1'b1;
      end
      RM_HIT: begin
        word_o[7] = 1'b1;
        word_o[6] = 1'b1;
        word_o[2] = tog2_i;
        flip2_o   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import sg_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned ADDR_W       = 20,
  parameter int unsigned SECTOR_BITS  = 11,
  parameter int unsigned BLOCK_BITS   = 15,
  parameter int unsigned PROG_CYCLES  = 8,
  parameter int unsigned ERASE_CYCLES = 40,
  parameter int unsigned CHIP_CYCLES  = 60,
  parameter int unsigned SUSP_LAT     = 5,
  parameter int unsigned SUSP_MAX     = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              suspended_o,
  output logic              done_o
);
  localparam int unsigned MAX_A = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned MAX_B = (CHIP_CYCLES > SUSP_LAT) ? CHIP_CYCLES : SUSP_LAT;
  localparam int unsigned MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW    = $clog2(MAXC + 1);
  localparam int unsigned RW    = ADDR_W - SECTOR_BITS;
  localparam int unsigned BOFF  = BLOCK_BITS - SECTOR_BITS;
  localparam int unsigned SAW   = $clog2(SUSP_MAX + 1);

  st_e              st_q, st_d;
  op_e              op_q, op_in;
  logic [RW-1:0]    region_q;
  logic             pbit7_q;
  logic [DATA_W-1:0] rd_data_q;
  logic             done_q;

  logic start_idle, start_nested, susp_acc, resume_acc;
  logic prog_load, prog_run, prog_exp;
  logic erase_load, erase_run, erase_exp;
  logic susp_run, susp_exp;
  logic [CW-1:0] prog_val, erase_val, susp_val;
  logic [CW-1:0] prog_remain, erase_remain, susp_remain;
  logic [1:0]    tog_q, tog_flip;
  rmode_e            rmode;
  logic [DATA_W-1:0] word;
  logic              flip6, flip2;
  logic              unused_bits;

  assign op_in       = op_e'(op_i);
  assign unused_bits = ^{prog_data_i, rd_addr_i[SECTOR_BITS-1:0], start_addr_i[SECTOR_BITS-1:0]};

  function automatic logic in_region(input logic [ADDR_W-1:0] a);
    logic [RW-1:0] up;
    up = a[ADDR_W-1:SECTOR_BITS];
    if (op_q == OP_BLK) return up[RW-1:BOFF] == region_q[RW-1:BOFF];
    return up == region_q;
  endfunction

  // job acceptance
  assign start_idle   = (st_q == ST_IDLE) && start_i;
  assign start_nested = (st_q == ST_SUSPENDED) && start_i && (op_in == OP_PROG)
                        && !in_region(start_addr_i);
  assign susp_acc     = (st_q == ST_ERASE) && suspend_i && (op_q != OP_CHIP) && !erase_exp;
  assign resume_acc   = (st_q == ST_SUSPENDED) && resume_i && !start_nested;

  assign prog_load  = (start_idle && op_in == OP_PROG) || start_nested;
  assign prog_val   = CW'(PROG_CYCLES - 1);
  assign prog_run   = (st_q == ST_PROG) || (st_q == ST_SUSP_PROG);
  assign erase_load = start_idle && (op_in != OP_PROG);
  assign erase_val  = (op_in == OP_CHIP) ? CW'(CHIP_CYCLES - 1) : CW'(ERASE_CYCLES - 1);
  assign erase_run  = (st_q == ST_ERASE) || (st_q == ST_SUSPENDING);
  assign susp_val   = CW'(SUSP_LAT - 1);
  assign susp_run   = (st_q == ST_SUSPENDING);

  sg_cycle_timer #(.CW(CW)) u_prog_tmr (
    .clk_i, .rst_ni, .load_i(prog_load), .load_val_i(prog_val), .run_i(prog_run),
    .expire_o(prog_exp), .remain_o(prog_remain)
  );
  sg_cycle_timer #(.CW(CW)) u_erase_tmr (
    .clk_i, .rst_ni, .load_i(erase_load), .load_val_i(erase_val), .run_i(erase_run),
    .expire_o(erase_exp), .remain_o(erase_remain)
  );
  sg_cycle_timer #(.CW(CW)) u_susp_tmr (
    .clk_i, .rst_ni, .load_i(susp_acc), .load_val_i(susp_val), .run_i(susp_run),
    .expire_o(susp_exp), .remain_o(susp_remain)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:       if (start_i) st_d = (op_in == OP_PROG) ? ST_PROG : ST_ERASE;
      ST_PROG:       if (prog_exp) st_d = ST_IDLE;
      ST_ERASE:      if (erase_exp) st_d = ST_IDLE;
                     else if (susp_acc) st_d = ST_SUSPENDING;
      ST_SUSPENDING: if (erase_exp) st_d = ST_IDLE;
                     else if (susp_exp) st_d = ST_SUSPENDED;
      ST_SUSPENDED:  if (start_nested) st_d = ST_SUSP_PROG;
                     else if (resume_acc) st_d = ST_ERASE;
      ST_SUSP_PROG:  if (prog_exp) st_d = ST_SUSPENDED;
      default:       st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_q)
      ST_PROG, ST_SUSP_PROG:   rmode = RM_PROG;
      ST_ERASE, ST_SUSPENDING: rmode = RM_ERASE;
      ST_SUSPENDED:            rmode = in_region(rd_addr_i) ? RM_HIT : RM_ARRAY;
      default:                 rmode = RM_ARRAY;
    endcase
  end

  sg_status_word #(.DATA_W(DATA_W)) u_word (
    .mode_i(rmode), .array_i(array_data_i), .pbit7_i(pbit7_q),
    .tog6_i(tog_q[1]), .tog2_i(tog_q[0]),
    .word_o(word), .flip6_o(flip6), .flip2_o(flip2)
  );

  assign tog_flip = {rd_i && flip6, rd_i && flip2};

  sg_toggle_bank #(.N(2)) u_tog (
    .clk_i, .rst_ni, .clear_i(start_idle || start_nested), .flip_i(tog_flip), .q_o(tog_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_PROG;
      region_q  <= '0;
      pbit7_q   <= 1'b0;
      rd_data_q <= '0;
      done_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= prog_exp || erase_exp;
      if (start_idle) begin
        op_q     <= op_in;
        region_q <= start_addr_i[ADDR_W-1:SECTOR_BITS];
      end
      if (prog_load) pbit7_q <= prog_data_i[7];
      if (rd_i) rd_data_q <= word;
    end
  end

  assign rd_data_o   = rd_data_q;
  assign done_o      = done_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign suspended_o = (st_q == ST_SUSPENDED) || (st_q == ST_SUSP_PROG);

  // checker: cycles spent entering suspend
  logic [SAW-1:0] susp_age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           susp_age_q <= '0;
    else if (st_q != ST_SUSPENDING)        susp_age_q <= '0;
    else if (susp_age_q != {SAW{1'b1}})    susp_age_q <= susp_age_q + 1'b1;
  end

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_start_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i) |=> busy_o);
  assert_idle_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && st_q == ST_IDLE) |=> rd_data_o == $past(array_data_i));
  assert_prog_poll_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && st_q == ST_PROG) |=> rd_data_o[7] == ~$past(pbit7_q));
  assert_erase_poll_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && st_q == ST_ERASE) |=> rd_data_o[7] == 1'b0);
  assert_hit_pair_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && st_q == ST_SUSPENDED && in_region(rd_addr_i)) |=> rd_data_o[7:6] == 2'b11);
  assert_ignore_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROG && start_i) |=> $stable(pbit7_q));
  assert_frozen_erase_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUSPENDED || st_q == ST_SUSP_PROG) |=> erase_remain == $past(erase_remain));
  assert_idle_prog_tmr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUSPENDED && !start_nested) |=> prog_remain == $past(prog_remain));
  assert_susp_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUSPENDING) |-> susp_remain < CW'(SUSP_LAT));
  assert_susp_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_age_q < SAW'(SUSP_MAX));
endmodule

// File: tb/tb_flash_status_gen.sv
`timescale 1ns/1ps
module tb_flash_status_gen;
  localparam int DW = 16, AW = 20, SB = 11, BB = 15;
  localparam int PC = 8, EC = 40, CC = 60, SL = 5, SM = 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, susp = 0, resm = 0, rd = 0;
  logic [1:0] op = 0;
  logic [AW-1:0] saddr = 0, raddr = 0;
  logic [DW-1:0] pdata = 0, arr = 0;
  logic [DW-1:0] rdata;
  logic busy, susp_o, done;

  int n_chk = 0, n_bad = 0;
  int act_cnt = 0, done_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_status_gen #(.DATA_W(DW), .ADDR_W(AW), .SECTOR_BITS(SB), .BLOCK_BITS(BB),
    .PROG_CYCLES(PC), .ERASE_CYCLES(EC), .CHIP_CYCLES(CC), .SUSP_LAT(SL), .SUSP_MAX(SM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .start_addr_i(saddr),
    .prog_data_i(pdata), .suspend_i(susp), .resume_i(resm), .rd_i(rd), .rd_addr_i(raddr),
    .array_data_i(arr), .rd_data_o(rdata), .busy_o(busy), .suspended_o(susp_o), .done_o(done));

  always @(negedge clk) if (rst_n) begin
    if (busy && !susp_o) act_cnt++;
    if (done) done_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  function automatic logic [DW-1:0] exp_prog(logic [DW-1:0] w, logic [DW-1:0] p, logic b6);
    w[7] = ~p[7]; w[6] = b6; w[2] = 1'b0; return w;
  endfunction
  function automatic logic [DW-1:0] exp_erase(logic [DW-1:0] w, logic b6, logic b2);
    w[7] = 1'b0; w[6] = b6; w[2] = b2; return w;
  endfunction
  function automatic logic [DW-1:0] exp_hit(logic [DW-1:0] w, logic b2);
    w[7] = 1'b1; w[6] = 1'b1; w[2] = b2; return w;
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] w, output logic [DW-1:0] got);
    rd = 1; raddr = a; arr = w;
    @(negedge clk);
    rd = 0;
    got = rdata;
  endtask

  task automatic start_job(input logic [1:0] o, input logic [AW-1:0] a, input logic [DW-1:0] d);
    start = 1; op = o; saddr = a; pdata = d;
    @(negedge clk);
    start = 0;
  endtask

  task automatic pulse_susp();
    susp = 1; @(negedge clk); susp = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (!done) chk({tag, " done timeout"}, 0, 1);
  endtask

  task automatic wait_susp(output int lat);
    lat = 0;
    while (!susp_o && lat < 200) begin lat++; @(negedge clk); end
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w, got, pd;
    logic [AW-1:0] sa, a;
    int a0, d0, lat;
    void'($urandom(32'd2718));

    // R1 reset state
    cyc(3);
    chk("R1 busy in reset", busy, 0);
    chk("R1 rdata in reset", rdata, 0);
    @(negedge clk) rst_n = 1;
    cyc(1);
    chk("R1 busy", busy, 0);
    chk("R1 suspended", susp_o, 0);
    chk("R1 done", done, 0);

    // R2 idle pass-through
    for (int i = 0; i < 20; i++) begin
      w = DW'($urandom);
      do_read(AW'($urandom), w, got);
      chk("R2 idle read", got, w);
    end
    cyc(2);
    chk("R2 hold without strobe", rdata, w);

    // R3 R4 R5 program status
    pd = 16'h0080;
    start_job(2'b00, 20'h00100, pd);
    for (int k = 0; k < 4; k++) begin
      w = DW'($urandom);
      do_read(20'h00100, w, got);
      chk("R3 R4 R5 program read", got, exp_prog(w, pd, k[0]));
    end
    wait_done("R7 prog");
    cyc(1);
    w = DW'($urandom);
    do_read(20'h00100, w, got);
    chk("R7 array after program", got, w);

    // R7 R8 program length, ignored commands
    a0 = act_cnt; d0 = done_cnt;
    start_job(2'b00, 20'h00200, 16'h1234);
    cyc(1);
    start = 1; op = 2'b01; saddr = 20'h40000; susp = 1;
    @(negedge clk); start = 0; susp = 0;
    chk("R8 no suspend in program", susp_o, 0);
    wait_done("R7 prog2");
    cyc(3);
    chk("R7 program cycles", act_cnt - a0, PC);
    chk("R7 done single", done_cnt - d0, 1);
    chk("R8 no erase started", busy, 0);

    // R4 R5 R6 sector erase status and length
    a0 = act_cnt;
    start_job(2'b01, 20'h12345, 0);
    for (int k = 0; k < 5; k++) begin
      w = DW'($urandom);
      do_read(AW'($urandom), w, got);
      chk("R4 R5 R6 erase read", got, exp_erase(w, k[0], k[0]));
    end
    wait_done("R7 erase");
    cyc(1);
    chk("R7 sector erase cycles", act_cnt - a0, EC);

    // R8 whole-array erase ignores suspend
    a0 = act_cnt;
    start_job(2'b11, 0, 0);
    cyc(3);
    pulse_susp();
    cyc(SL + 3);
    chk("R8 chip erase not suspended", susp_o, 0);
    wait_done("R7 chip");
    cyc(1);
    chk("R7 chip erase cycles", act_cnt - a0, CC);

    // R9 R10 R11 R12 sector erase with suspend
    sa = 20'h12345;
    a0 = act_cnt; d0 = done_cnt;
    start_job(2'b01, sa, 0);
    cyc(6);
    pulse_susp();
    wait_susp(lat);
    chk("R9 suspend latency", lat, SL);
    for (int k = 0; k < 3; k++) begin
      w = DW'($urandom);
      do_read({sa[AW-1:SB], SB'($urandom)}, w, got);
      chk("R10 in-sector read", got, exp_hit(w, k[0]));
    end
    w = DW'($urandom);
    do_read(sa ^ (20'h1 << SB), w, got);
    chk("R10 outside sector read", got, w);
    start_job(2'b00, sa, 16'hFFFF);
    w = DW'($urandom);
    do_read(sa, w, got);
    chk("R11 in-region program ignored", got, exp_hit(w, 1'b1));
    chk("R11 still suspended", susp_o, 1);
    pd = DW'($urandom);
    start_job(2'b00, sa ^ (20'h1 << 16), pd);
    for (int k = 0; k < 2; k++) begin
      w = DW'($urandom);
      do_read(sa, w, got);
      chk("R11 nested program read", got, exp_prog(w, pd, k[0]));
    end
    wait_done("R11 nested");
    chk("R11 suspended after nested", susp_o, 1);
    cyc(1);
    w = DW'($urandom);
    do_read(sa, w, got);
    chk("R4 toggles cleared by nested job", got, exp_hit(w, 1'b0));
    resm = 1; @(negedge clk); resm = 0;
    chk("R12 resumed", susp_o, 0);
    wait_done("R12 erase");
    cyc(1);
    chk("R12 erase cycles across suspend", act_cnt - a0, EC);
    chk("R11 R12 done pulses", done_cnt - d0, 2);

    // R10 block granularity, R1 abort while suspended
    sa = 20'h48000;
    start_job(2'b10, sa, 0);
    cyc(4);
    pulse_susp();
    wait_susp(lat);
    chk("R9 block suspend latency", lat, SL);
    w = DW'($urandom);
    do_read(sa ^ (20'h1 << SB), w, got);
    chk("R10 block region other sector", got, exp_hit(w, 1'b0));
    w = DW'($urandom);
    do_read(sa ^ (20'h1 << BB), w, got);
    chk("R10 outside block", got, w);
    rst_n = 0; cyc(2); rst_n = 1; cyc(1);
    chk("R1 abort busy", busy, 0);
    chk("R1 abort suspended", susp_o, 0);
    w = DW'($urandom);
    do_read(sa, w, got);
    chk("R1 array after abort", got, w);

    // R1 abort of a running program
    start_job(2'b00, 20'h00300, 16'h00FF);
    cyc(2);
    rst_n = 0; cyc(1); rst_n = 1; cyc(1);
    chk("R1 program aborted", busy, 0);

    // random programs and idle reads
    for (int j = 0; j < 12; j++) begin
      pd = DW'($urandom);
      a = AW'($urandom);
      start_job(2'b00, a, pd);
      for (int k = 0; k < 1 + int'($urandom % 4); k++) begin
        w = DW'($urandom);
        do_read(AW'($urandom), w, got);
        chk("R3 R4 random program read", got, exp_prog(w, pd, k[0]));
      end
      wait_done("R7 random");
      cyc(1);
      w = DW'($urandom);
      do_read(a, w, got);
      chk("R2 random idle read", got, w);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule